// File: doc/BRIEF.md
# Cell Voltage Protection Controller

This block decides the enables of the charge switch and the discharge switch of a single-cell battery pack. It receives digital flags from external comparators: cell voltage against the over-charge, over-charge release, over-discharge, over-discharge release and near-zero-volt inhibit levels. It also receives a charger-present flag, a charge over-current flag with its release flag, and a one-pulse-per-millisecond tick. Every fault is confirmed by a qualified detection delay and cleared by a qualified release delay. All delays are counted in ticks and set by parameters.

The controller has four modes. In normal mode both switches are on. In over-charge mode the charge switch is off. In over-discharge mode the discharge switch is off, and while no charger is attached the block is in shutdown: bias is removed and the current-sense pull-up is enabled. In charge over-current mode the charge switch is off. Charge over-current checking is masked during over-discharge. A near-zero-volt cell blocks charging in every mode.

Top module: `cellguard_ctrl`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) the block is in normal mode: chg_on=1, dchg_on=1, shutdown=0, cs_pullup=0, provided zv_low=0.
- R2: In normal mode, ov_det held high for T_OV_DET ticks drives chg_on to 0 one clock after the edge that counts the last tick. dchg_on stays 1.
- R3: Over-charge mode is left only when chgr_present=0 and ov_rel stays high for T_OV_REL ticks. chg_on then returns to 1. With the charger present, ov_rel has no effect.
- R4: In normal mode, uv_det held high for T_UV_DET ticks drives dchg_on to 0 one clock after the edge that counts the last tick. With chgr_present=0, shutdown=1 and cs_pullup=1.
- R5: Shutdown (shutdown=1, cs_pullup=1) lasts exactly while the block is in over-discharge mode with chgr_present=0. Normal mode resumes (dchg_on=1) only after uv_rel stays high for T_UV_REL ticks with the charger present. Without the charger, uv_rel has no effect.
- R6: In over-discharge mode, coc_det has no effect for any duration. Charge over-current detection is armed again once normal mode resumes.
- R7: In normal mode, coc_det held high for T_COC_DET ticks drives chg_on to 0. It returns to 1 only after chgr_present=0 and coc_rel stays high for T_COC_REL ticks.
- R8: While zv_low=1, chg_on=0 in the same cycle, in every mode. Once zv_low falls, chg_on takes the value its mode gives.
- R9: Each delay counter clears whenever its qualifying condition drops before expiry. An interrupted qualification of any length shorter than the delay, followed by delay-minus-one further ticks, does not trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse per millisecond; the delay time base |
| chgr_present | input | 1 | Charger attached |
| ov_det | input | 1 | Cell at or above the over-charge level |
| ov_rel | input | 1 | Cell below the over-charge release level |
| uv_det | input | 1 | Cell below the over-discharge level |
| uv_rel | input | 1 | Cell above the over-discharge release level |
| zv_low | input | 1 | Cell below the near-zero-volt charge inhibit level |
| coc_det | input | 1 | Charge current beyond its over-current limit |
| coc_rel | input | 1 | Charge over-current release condition met |
| chg_on | output | 1 | Charge switch enable |
| dchg_on | output | 1 | Discharge switch enable |
| shutdown | output | 1 | Low-power shutdown, bias removed |
| cs_pullup | output | 1 | Current-sense pin pull-up enable |

## Verification
A mode change becomes visible one clock after the edge that counts the final qualifying tick. The counter reaches its limit on that tick edge, and the mode register moves on the next edge. The bench therefore samples at the falling edge right after the final tick, expecting the old outputs, and again one falling edge later, expecting the new ones. The zero-volt inhibit and the shutdown flag are combinational from the mode and the inputs, so they are checked at the falling edge where their input changed. The restart rule is swept over every interruption point of the over-charge delay.

// File: rtl/cellguard_pkg.sv
// Shared types of the cell protection controller.
// Assumes: timer indices below are the order of the per-fault delay counters.
package cellguard_pkg;

    typedef enum logic [1:0] {
        M_NORMAL = 2'd0,
        M_OVCHG  = 2'd1,
        M_OVDIS  = 2'd2,
        M_COC    = 2'd3
    } mode_e;

    localparam int NTMR    = 6;
    localparam int TI_OVD  = 0;  // over-charge detect
    localparam int TI_OVR  = 1;  // over-charge release
    localparam int TI_UVD  = 2;  // over-discharge detect
    localparam int TI_UVR  = 3;  // over-discharge release
    localparam int TI_COCD = 4;  // charge over-current detect
    localparam int TI_COCR = 5;  // charge over-current release

endpackage

// File: rtl/cellguard_delay.sv
// Qualified delay counter: counts ticks while its condition holds and flags
// expiry once LIMIT ticks have been seen.
// Assumes: LIMIT >= 1; the condition is already gated by the owning mode.
module cellguard_delay #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic qual,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] cnt_q;

    // Count qualifying ticks, saturate at the limit, clear when the condition drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!qual) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != LIM)) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    // Expiry is only meaningful while the condition still holds.
    assign expired = qual && (cnt_q == LIM);

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM);
    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !qual |=> (cnt_q == '0));

endmodule

// File: rtl/cellguard_seq.sv
// Mode sequencer: builds the per-timer qualifying conditions from the mode
// and the comparator flags, moves between modes on timer expiry and
// decodes the switch enables.
// Assumes: expiry flags come from counters fed by the qual vector.
module cellguard_seq
    import cellguard_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            chgr_present,
    input  logic            ov_det,
    input  logic            ov_rel,
    input  logic            uv_det,
    input  logic            uv_rel,
    input  logic            zv_low,
    input  logic            coc_det,
    input  logic            coc_rel,
    input  logic [NTMR-1:0] done,
    output logic [NTMR-1:0] qual,
    output logic            chg_on,
    output logic            dchg_on,
    output logic            shutdown,
    output logic            cs_pullup
);
    mode_e mode_q, mode_d;

    // Qualifying conditions; each timer only runs in the mode that uses it.
    always_comb begin
        qual          = '0;
        qual[TI_OVD]  = (mode_q == M_NORMAL) && ov_det;
        qual[TI_UVD]  = (mode_q == M_NORMAL) && uv_det;
        qual[TI_COCD] = (mode_q == M_NORMAL) && coc_det;
        qual[TI_OVR]  = (mode_q == M_OVCHG) && !chgr_present && ov_rel;
        qual[TI_UVR]  = (mode_q == M_OVDIS) && chgr_present && uv_rel;
        qual[TI_COCR] = (mode_q == M_COC) && !chgr_present && coc_rel;
    end

    // Next mode: over-discharge outranks over-charge, which outranks over-current.
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            M_NORMAL: begin
                if (done[TI_UVD])       mode_d = M_OVDIS;
                else if (done[TI_OVD])  mode_d = M_OVCHG;
                else if (done[TI_COCD]) mode_d = M_COC;
            end
            M_OVCHG: if (done[TI_OVR])  mode_d = M_NORMAL;
            M_OVDIS: if (done[TI_UVR])  mode_d = M_NORMAL;
            M_COC:   if (done[TI_COCR]) mode_d = M_NORMAL;
            default: mode_d = M_NORMAL;
        endcase
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= M_NORMAL;
        else        mode_q <= mode_d;
    end

    // Output decode; charging stays allowed in over-discharge so the cell can recover.
    always_comb begin
        chg_on    = !zv_low && ((mode_q == M_NORMAL) || (mode_q == M_OVDIS));
        dchg_on   = (mode_q != M_OVDIS);
        shutdown  = (mode_q == M_OVDIS) && !chgr_present;
        cs_pullup = shutdown;
    end

    p_ov_trip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_NORMAL && done[TI_OVD] && !done[TI_UVD]) |=> !chg_on);
    p_ov_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_q) == M_OVCHG && mode_q == M_NORMAL) |-> $past(!chgr_present));
    p_uv_trip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_NORMAL && done[TI_UVD]) |=> !dchg_on);
    p_shutdown_r5: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> (!dchg_on && cs_pullup && !chgr_present));
    p_coc_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_OVDIS) |=> (mode_q != M_COC));
    p_coc_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_q) == M_COC && mode_q == M_NORMAL) |-> $past(!chgr_present));
    p_zero_volt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        zv_low |-> !chg_on);

endmodule

// File: rtl/cellguard_ctrl.sv
// Top of the single-cell protection controller: one qualified delay counter
// per fault detection and release, driven by the mode sequencer.
// Assumes: comparator flags are already synchronous to clk; tick is one cycle wide.
module cellguard_ctrl
    import cellguard_pkg::*;
#(
    parameter int unsigned T_OV_DET  = 1000,
    parameter int unsigned T_OV_REL  = 16,
    parameter int unsigned T_UV_DET  = 20,
    parameter int unsigned T_UV_REL  = 1,
    parameter int unsigned T_COC_DET = 16,
    parameter int unsigned T_COC_REL = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic chgr_present,
    input  logic ov_det,
    input  logic ov_rel,
    input  logic uv_det,
    input  logic uv_rel,
    input  logic zv_low,
    input  logic coc_det,
    input  logic coc_rel,
    output logic chg_on,
    output logic dchg_on,
    output logic shutdown,
    output logic cs_pullup
);
    localparam int unsigned LIM_A [NTMR] =
        '{T_OV_DET, T_OV_REL, T_UV_DET, T_UV_REL, T_COC_DET, T_COC_REL};

    logic [NTMR-1:0] qual;
    logic [NTMR-1:0] done;

    cellguard_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .chgr_present (chgr_present),
        .ov_det       (ov_det),
        .ov_rel       (ov_rel),
        .uv_det       (uv_det),
        .uv_rel       (uv_rel),
        .zv_low       (zv_low),
        .coc_det      (coc_det),
        .coc_rel      (coc_rel),
        .done         (done),
        .qual         (qual),
        .chg_on       (chg_on),
        .dchg_on      (dchg_on),
        .shutdown     (shutdown),
        .cs_pullup    (cs_pullup)
    );

    // One delay counter per detection and release condition.
    for (genvar g = 0; g < NTMR; g++) begin : g_tmr
        cellguard_delay #(.LIMIT(LIM_A[g])) u_dly (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .qual    (qual[g]),
            .expired (done[g])
        );
    end

endmodule

// File: tb/cellguard_ctrl_bench.sv
`timescale 1ns/1ps
module cellguard_ctrl_bench;
    localparam int OVD = 6;
    localparam int OVR = 3;
    localparam int UVD = 4;
    localparam int UVR = 2;
    localparam int CD  = 5;
    localparam int CR  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, chgr_present = 1'b0, ov_det = 1'b0, ov_rel = 1'b0;
    logic uv_det = 1'b0, uv_rel = 1'b0, zv_low = 1'b0, coc_det = 1'b0, coc_rel = 1'b0;
    logic chg_on, dchg_on, shutdown, cs_pullup;

    int nvec = 0;
    int nfail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    cellguard_ctrl #(
        .T_OV_DET(OVD), .T_OV_REL(OVR), .T_UV_DET(UVD),
        .T_UV_REL(UVR), .T_COC_DET(CD), .T_COC_REL(CR)
    ) u_cellguard_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .chgr_present(chgr_present),
        .ov_det(ov_det), .ov_rel(ov_rel), .uv_det(uv_det), .uv_rel(uv_rel),
        .zv_low(zv_low), .coc_det(coc_det), .coc_rel(coc_rel),
        .chg_on(chg_on), .dchg_on(dchg_on), .shutdown(shutdown), .cs_pullup(cs_pullup)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, act, exp);
        end
    endtask

    // n tick pulses; starts and ends just after a falling edge.
    task automatic pulse(input int n);
        repeat (n) begin
            tick = 1'b1;
            @(negedge clk); #1;
            tick = 1'b0;
            @(negedge clk); #1;
        end
    endtask

    // Final tick: leaves the caller one cycle before the mode register moves.
    task automatic last_tick();
        tick = 1'b1;
        @(negedge clk); #1;
        tick = 1'b0;
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        step();
        // R1: reset state
        chk("R1", "chg_on", chg_on, 1'b1);
        chk("R1", "dchg_on", dchg_on, 1'b1);
        chk("R1", "shutdown", shutdown, 1'b0);
        chk("R1", "cs_pullup", cs_pullup, 1'b0);

        // R9: sweep every interruption point of the over-charge delay
        for (int k = 1; k < OVD; k++) begin
            ov_det = 1'b1;
            pulse(k);
            ov_det = 1'b0;
            step();
            ov_det = 1'b1;
            pulse(OVD - 1);
            chk("R9", $sformatf("no trip after break at %0d", k), chg_on, 1'b1);
            ov_det = 1'b0;
            step();
        end

        // R2: over-charge detection timing
        ov_det = 1'b1;
        pulse(OVD - 1);
        last_tick();
        chk("R2", "chg_on before move", chg_on, 1'b1);
        step();
        chk("R2", "chg_on after delay", chg_on, 1'b0);
        chk("R2", "dchg_on kept", dchg_on, 1'b1);
        ov_det = 1'b0;

        // R3: release blocked by charger, then released without it
        chgr_present = 1'b1;
        ov_rel = 1'b1;
        pulse(OVR + 2);
        chk("R3", "no release with charger", chg_on, 1'b0);
        chgr_present = 1'b0;
        pulse(OVR - 1);
        last_tick();
        chk("R3", "chg_on before move", chg_on, 1'b0);
        step();
        chk("R3", "chg_on released", chg_on, 1'b1);
        ov_rel = 1'b0;

        // R7: charge over-current detect and release
        chgr_present = 1'b1;
        coc_det = 1'b1;
        pulse(CD - 1);
        last_tick();
        chk("R7", "chg_on before move", chg_on, 1'b1);
        step();
        chk("R7", "chg_on tripped", chg_on, 1'b0);
        chk("R7", "dchg_on kept", dchg_on, 1'b1);
        coc_det = 1'b0;
        coc_rel = 1'b1;
        pulse(CR + 1);
        chk("R7", "no release with charger", chg_on, 1'b0);
        chgr_present = 1'b0;
        pulse(CR - 1);
        last_tick();
        chk("R7", "chg_on before move", chg_on, 1'b0);
        step();
        chk("R7", "chg_on released", chg_on, 1'b1);
        coc_rel = 1'b0;

        // R8: zero-volt inhibit in normal mode, same cycle
        zv_low = 1'b1;
        #1 chk("R8", "chg_on inhibited", chg_on, 1'b0);
        chk("R8", "dchg_on untouched", dchg_on, 1'b1);
        zv_low = 1'b0;
        #1 chk("R8", "chg_on restored", chg_on, 1'b1);
        step();

        // R4: over-discharge detect, shutdown without charger
        uv_det = 1'b1;
        pulse(UVD - 1);
        last_tick();
        chk("R4", "dchg_on before move", dchg_on, 1'b1);
        step();
        chk("R4", "dchg_on tripped", dchg_on, 1'b0);
        chk("R4", "shutdown", shutdown, 1'b1);
        chk("R4", "cs_pullup", cs_pullup, 1'b1);
        uv_det = 1'b0;

        // R8: inhibit also in over-discharge mode
        zv_low = 1'b1;
        #1 chk("R8", "chg_on inhibited in shutdown", chg_on, 1'b0);
        zv_low = 1'b0;
        #1 chk("R8", "chg_on back in over-discharge", chg_on, 1'b1);

        // R5: release flag without charger has no effect
        uv_rel = 1'b1;
        pulse(UVR + 3);
        chk("R5", "dchg_on held without charger", dchg_on, 1'b0);
        chk("R5", "shutdown held", shutdown, 1'b1);
        uv_rel = 1'b0;

        // R6: charge over-current masked in over-discharge
        chgr_present = 1'b1;
        coc_det = 1'b1;
        #1 chk("R5", "shutdown left on charger", shutdown, 1'b0);
        chk("R5", "cs_pullup off on charger", cs_pullup, 1'b0);
        pulse(CD + 3);
        chk("R6", "chg_on with masked over-current", chg_on, 1'b1);
        coc_det = 1'b0;

        // R5: release with charger after the release delay
        uv_rel = 1'b1;
        pulse(UVR - 1);
        last_tick();
        chk("R5", "dchg_on before move", dchg_on, 1'b0);
        step();
        chk("R5", "dchg_on released", dchg_on, 1'b1);
        uv_rel = 1'b0;

        // R6: over-current detection armed again in normal mode
        coc_det = 1'b1;
        pulse(CD - 1);
        last_tick();
        step();
        chk("R6", "over-current re-armed", chg_on, 1'b0);
        coc_det = 1'b0;
        chgr_present = 1'b0;
        coc_rel = 1'b1;
        pulse(CR);
        chk("R7", "chg_on released again", chg_on, 1'b1);
        coc_rel = 1'b0;
        step();

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            nfail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

endmodule